// File: doc/BRIEF.md
# Port Power Budget Admission Sequencer

This block decides whether a port whose attached device has just been classified may be switched on. Several ports share one power budget. The budget is kept on a common allocation node, and each port adds a current in proportion to the power it claims. The block sees that node only through one comparator bit, which tells it whether the summed allocation is above the limit.

When a classification result arrives, the block runs a fixed sequence:

1. It checks the comparator.
2. If there is headroom, it places its own claim on the node.
3. It waits a programmable settle time.
4. It checks the comparator again.
5. It then does one of two things:
   - If the level is still below the limit, it pulses a grant and keeps the claim in place until the port is switched off.
   - If the level has gone over the limit, it withdraws the claim and pulses an abort, and port control goes back to detection.

A bypass input stands for a system that has no budget management. With bypass set, every check passes.

Top module: `pbudget_admit`

## Requirements
- R1: Out of reset, `claim_code` is 0 and `grant` and `abort` are low.
- R2: A `class_valid` sampled in idle starts the pre-check in that same clock cycle. If `level_over` is 1 and `bypass` is 0, `abort` pulses one cycle after that clock edge and `claim_code` stays 0.
- R3: The claim code is derived from `class_code`. Classes 0, 3 and 4 map to 3 (full, 15.4 W). Class 2 maps to 2 (medium, 7 W). Class 1 maps to 1 (small, 4 W). Codes 5 to 7 are treated as full (3). Code 0 on `claim_code` means no claim.
- R4: When the pre-check passes, `claim_code` carries the class claim from the first clock edge after `class_valid` is sampled.
- R5: The re-check samples `level_over` on the (`settle_ticks`+1)-th clock edge after the claim appears. Until that edge, `grant` and `abort` stay low and `claim_code` does not change.
- R6: If the re-check passes (`level_over` is 0, or `bypass` is 1), `grant` pulses for exactly one cycle and the claim stays in place.
- R7: If the re-check fails, `claim_code` returns to 0 and `abort` pulses for exactly one cycle, both after the same clock edge.
- R8: A granted claim stays unchanged, and `class_valid` is ignored, until `port_off` is sampled. After that edge, `claim_code` is 0 and the block is idle.
- R9: `grant` and `abort` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| class_valid | input | 1 | Classification result is present |
| class_code | input | 3 | Classification result |
| level_over | input | 1 | Shared allocation level is above the threshold |
| bypass | input | 1 | No budget management: every check passes |
| port_off | input | 1 | Port has been switched off; release the claim |
| settle_ticks | input | SETTLE_W (8) | Extra settle cycles before the re-check |
| claim_code | output | 2 | 0 none, 1 small, 2 medium, 3 full |
| grant | output | 1 | One-cycle pulse: port may be powered |
| abort | output | 1 | One-cycle pulse: admission refused |

## Verification
A pre-check abort and the start of the claim are both due one clock edge after `class_valid` is sampled. The re-check result (`grant`, or `abort` together with the claim being cleared) is due `settle_ticks`+1 edges after that. The release after `port_off` is due on the next edge. The bench drives inputs on falling edges and counts rising edges to each of these points. It samples on the following falling edge, and checks that no pulse appears early on any intermediate cycle. It sweeps every class code, settle values 0 to 3, bypass on and off, and three comparator histories: over before the claim, over after the claim, and never over.

// File: rtl/pb_pkg.sv
package pb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_HELD   = 3'd2
   } pb_state_t;

   typedef enum logic [1:0] {
      CLAIM_NONE = 2'd0,
      CLAIM_SML  = 2'd1,
      CLAIM_MED  = 2'd2,
      CLAIM_FULL = 2'd3
   } pb_claim_t;

endpackage

// File: rtl/pb_share_map.sv
module pb_share_map
   import pb_pkg::*;
#(
   parameter int CLASS_W = 3
) (
   input  logic [CLASS_W-1:0] class_code,
   output pb_claim_t          share
);
   always_comb begin
      case (class_code)
         CLASS_W'(1): share = CLAIM_SML;
         CLASS_W'(2): share = CLAIM_MED;
         default:     share = CLAIM_FULL;
      endcase
   end
endmodule

// File: rtl/pb_settle_timer.sv
module pb_settle_timer #(
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SETTLE_W-1:0] load_val,
   input  logic                run,
   output logic                done
);
   logic [SETTLE_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (run && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // R5
   cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pb_level_sync.sv
module pb_level_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic level_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign level_out = level_in;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               sh_q <= '0;
            else
               sh_q <= {sh_q[STAGES-2+((STAGES==1)?1:0):0], level_in};
         end
         assign level_out = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pbudget_admit.sv
module pbudget_admit
   import pb_pkg::*;
#(
   parameter int CLASS_W     = 3,
   parameter int SETTLE_W    = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                class_valid,
   input  logic [CLASS_W-1:0]  class_code,
   input  logic                level_over,
   input  logic                bypass,
   input  logic                port_off,
   input  logic [SETTLE_W-1:0] settle_ticks,
   output logic [1:0]          claim_code,
   output logic                grant,
   output logic                abort
);
   localparam int MIN_CLASS_W = 3;

   generate
      if (CLASS_W < MIN_CLASS_W) begin : g_bad_class
         $error("CLASS_W must hold class codes 0..4");
      end
      if (SETTLE_W < 1 || SETTLE_W > 24) begin : g_bad_settle
         $error("SETTLE_W out of range 1..24");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES out of range 0..3");
      end
   endgenerate

   pb_state_t state_q;
   pb_claim_t claim_q, share;
   logic      grant_q, abort_q;
   logic      lvl, over, tmr_done, tmr_load;

   pb_share_map #(.CLASS_W(CLASS_W)) u_map (
      .class_code (class_code),
      .share      (share)
   );

   pb_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_in  (level_over),
      .level_out (lvl)
   );

   assign over     = lvl && !bypass;
   assign tmr_load = (state_q == ST_IDLE) && class_valid && !over;

   pb_settle_timer #(.SETTLE_W(SETTLE_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (settle_ticks),
      .run      (state_q == ST_SETTLE),
      .done     (tmr_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         claim_q <= CLAIM_NONE;
         grant_q <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         grant_q <= 1'b0;
         abort_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (class_valid) begin
                  if (over) begin
                     abort_q <= 1'b1;
                  end else begin
                     claim_q <= share;
                     state_q <= ST_SETTLE;
                  end
               end
            end
            ST_SETTLE: begin
               if (tmr_done) begin
                  if (over) begin
                     claim_q <= CLAIM_NONE;
                     abort_q <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     grant_q <= 1'b1;
                     state_q <= ST_HELD;
                  end
               end
            end
            ST_HELD: begin
               if (port_off) begin
                  claim_q <= CLAIM_NONE;
                  state_q <= ST_IDLE;
               end
            end
            default: begin
               state_q <= ST_IDLE;
               claim_q <= CLAIM_NONE;
            end
         endcase
      end
   end

   assign claim_code = claim_q;
   assign grant      = grant_q;
   assign abort      = abort_q;

   // R9
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && abort));
   // R6
   grant_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (claim_code != 2'd0));
   // R7
   abort_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> (claim_code == 2'd0));
   // R6
   grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> !grant);
   // R8
   held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HELD && !port_off) |=> $stable(claim_code));
   // R8
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HELD && port_off) |=> (claim_code == 2'd0));
   // R2
   precheck_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && class_valid && over) |=> (abort && claim_code == 2'd0));
endmodule

// File: tb/pbudget_admit_test.sv
module pbudget_admit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       class_valid = 1'b0;
   logic [2:0] class_code = '0;
   logic       level_over = 1'b0;
   logic       bypass = 1'b0;
   logic       port_off = 1'b0;
   logic [7:0] settle_ticks = '0;
   logic [1:0] claim_code;
   logic       grant, abort;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pbudget_admit uut (
      .clk(clk), .rst_n(rst_n), .class_valid(class_valid), .class_code(class_code),
      .level_over(level_over), .bypass(bypass), .port_off(port_off),
      .settle_ticks(settle_ticks), .claim_code(claim_code), .grant(grant), .abort(abort)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int share_of(input int c);
      if (c == 1) return 1;
      if (c == 2) return 2;
      return 3;
   endfunction

   // One admission attempt. pre/post: comparator before and after the claim.
   task automatic trial(input int c, input int s, input bit byp, input bit pre, input bit post);
      int exp_sh;
      exp_sh = share_of(c);
      bypass = byp;
      level_over = pre;
      class_code = 3'(c);
      settle_ticks = 8'(s);
      class_valid = 1'b1;
      step();
      class_valid = 1'b0;
      if (pre && !byp) begin
         chk("R2 abort", abort, 1);
         chk("R2 claim", claim_code, 0);
         chk("R9 grant", grant, 0);
         level_over = 1'b0;
         step();
         chk("R2 single", abort, 0);
         return;
      end
      chk("R4 claim", claim_code, exp_sh);
      chk("R3 map", claim_code, exp_sh);
      chk("R5 no abort", abort, 0);
      level_over = post;
      for (int k = 0; k < s; k++) begin
         step();
         chk("R5 early grant", grant, 0);
         chk("R5 early abort", abort, 0);
         chk("R5 claim", claim_code, exp_sh);
      end
      step();
      if (post && !byp) begin
         chk("R7 abort", abort, 1);
         chk("R7 claim", claim_code, 0);
         chk("R9 grant", grant, 0);
         level_over = 1'b0;
         step();
         chk("R7 single", abort, 0);
      end else begin
         chk("R6 grant", grant, 1);
         chk("R6 claim", claim_code, exp_sh);
         chk("R9 abort", abort, 0);
         // R8: class_valid ignored while held
         class_code = 3'd1;
         class_valid = 1'b1;
         level_over = 1'b1;
         step();
         class_valid = 1'b0;
         chk("R6 single", grant, 0);
         chk("R8 held", claim_code, exp_sh);
         chk("R8 no abort", abort, 0);
         level_over = 1'b0;
         port_off = 1'b1;
         step();
         port_off = 1'b0;
         chk("R8 release", claim_code, 0);
         step();
         chk("R8 idle", claim_code, 0);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) step();
      chk("R1 claim", claim_code, 0);
      chk("R1 grant", grant, 0);
      chk("R1 abort", abort, 0);
      rst_n = 1'b1;
      step();
      chk("R1 idle", claim_code, 0);
      for (int c = 0; c < 8; c++)
         for (int s = 0; s < 4; s++)
            for (int b = 0; b < 2; b++)
               for (int h = 0; h < 3; h++)
                  trial(c, s, b[0], h == 0, h == 1);
      // longer settle window
      trial(4, 9, 1'b0, 1'b0, 1'b1);
      trial(2, 9, 1'b0, 1'b0, 1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule